// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Interrupts

This block sits between a host register port and an audio serializer. On the playback side the host writes 32-bit sample words into a 32-entry queue. The serializer takes them through a valid/ready output stream. On the capture side the serializer pushes words through a valid/ready input stream, and the host pops them by reading a data register. Both queues report their fill level in a 6-bit field, so a full count of 32 can be represented.

The block raises a single interrupt line. Three status conditions feed it, and each has its own enable:
- the playback queue has drained to or below a programmable level;
- the serializer asked for a word while the playback queue was empty (underrun);
- the capture queue has filled to or above a programmable level.

Each threshold field holds the threshold minus one. A second register gives level-based request outputs for an external DMA engine. A clear register flushes either queue. The flush bit reads back 1 while the flush is in progress and returns to 0 by itself.

Stream rules: `tx_valid` is high whenever the playback queue holds a word and no flush is pending. Once `tx_valid` is high, `tx_data` stays stable until a cycle with `tx_ready` high takes the word, unless a flush is written. `rx_ready` is low while the capture queue is full or flushing, and a word offered with `rx_ready` low is not taken. Register reads are combinational. A read strobe on the capture data register pops one word at the clock edge.

Top module: `audio_fifo_ctl`

## Requirements
- R1: Each queue stores up to 32 words and returns them in write order. Its fill level reads back in bits 5:0 of the level register: index 6 for playback, index 7 for capture.
- R2: A host write to the playback data register (index 4) while 32 words are stored is dropped. The stored words come out unchanged.
- R3: Status bit 0 (status register index 1) is high while the playback level is at or below the control-register field at bits 8:4 plus one. The interrupt carries this condition when control bit 0 is set.
- R4: Status bit 1 (underrun) is set when `tx_ready` is high while the playback queue is empty. It stays set until a control-register write with bit 2 set. It drives the interrupt when control bit 1 is set.
- R5: Status bit 16 is high while the capture level is at or above the control field at bits 24:20 plus one. The interrupt carries this condition when control bit 16 is set.
- R6: Writing 1 to bit 0 (playback) or bit 1 (capture) of the clear register (index 3) empties that queue. The bit reads 1 in the cycle after the write and 0 afterwards. While the flush is pending, `tx_valid` or `rx_ready` is low.
- R7: The DMA register (index 2) holds a playback level at bits 4:0 with its enable at bit 8, and a capture level at bits 20:16 with its enable at bit 24. `tx_dma_req` is high when its enable is set and the playback level is at or below its level field. `rx_dma_req` is high when its enable is set and the capture level is above its level field.
- R8: Back-pressure is obeyed on both streams. `tx_data` is held while `tx_valid` is high and `tx_ready` is low. `rx_ready` is low when the capture queue holds 32 words.
- R9: After reset both queues are empty, every control field and enable is 0, the interrupt and DMA requests are low, and the status register reads 0x1.
- R10: The control register (index 0) reads back its written enables and threshold fields. Bit 2 is an action and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on capture data) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Playback word available |
| tx_ready | input | 1 | Serializer takes playback word |
| tx_data | output | DW | Playback word |
| rx_valid | input | 1 | Capture word offered |
| rx_ready | output | 1 | Capture queue accepts word |
| rx_data | input | DW | Capture word |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Playback DMA request |
| rx_dma_req | output | 1 | Capture DMA request |

## Verification
The bench fills the playback queue past 32 words. A design that wrapped its pointers on the extra write would return the 33rd word in place of the first. It probes both threshold comparisons exactly at and one step past the boundary, because an off-by-one in the minus-one decoding moves the interrupt edge by a word. It reads the clear bit in the one cycle the flush is pending and again afterwards: a bit that never self-clears, or that clears before the pointers reset, is caught. The underrun flag is checked to survive idle cycles and to drop only on the clear write, and the capture stream is driven into a full queue to confirm that `rx_ready` falls and no word is lost.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] A_CTL  = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_DMA  = 3'd2;
  localparam logic [2:0] A_CLR  = 3'd3;
  localparam logic [2:0] A_TXD  = 3'd4;
  localparam logic [2:0] A_RXD  = 3'd5;
  localparam logic [2:0] A_TXL  = 3'd6;
  localparam logic [2:0] A_RXL  = 3'd7;

  localparam int B_TXE_EN   = 0;
  localparam int B_UND_EN   = 1;
  localparam int B_UND_CLR  = 2;
  localparam int B_TX_THR   = 4;
  localparam int B_RXF_EN   = 16;
  localparam int B_RX_THR   = 20;

  localparam int B_TXDMA_LVL = 0;
  localparam int B_TXDMA_EN  = 8;
  localparam int B_RXDMA_LVL = 16;
  localparam int B_RXDMA_EN  = 24;

  localparam int B_CLR_TX = 0;
  localparam int B_CLR_RX = 1;

  localparam int N_PATH = 2;
  localparam int P_TX   = 0;
  localparam int P_RX   = 1;
endpackage

// File: rtl/afc_store.sv
module afc_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/afc_regs.sv
module afc_regs
  import afc_pkg::*;
#(
  parameter int DW = 32,
  parameter int TW = 5,
  localparam int LW = TW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [LW-1:0]    tx_level,
  input  logic [LW-1:0]    rx_level,
  input  logic             tx_full,
  input  logic             rx_empty,
  input  logic [DW-1:0]    rx_head,
  input  logic             underrun_evt,
  output logic             tx_push,
  output logic [DW-1:0]    tx_wdata,
  output logic             rx_pop,
  output logic             tx_flush,
  output logic             rx_flush,
  output logic             underrun,
  output logic             irq,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);
  logic          txe_en, und_en, rxf_en;
  logic [TW-1:0] tx_thr_f, rx_thr_f;
  logic [TW-1:0] tx_dlvl, rx_dlvl;
  logic          tx_den, rx_den;
  logic          txe_st, rxf_st;
  logic          wr_ctl, wr_dma, wr_clr;

  assign wr_ctl = reg_wr && (reg_addr == A_CTL);
  assign wr_dma = reg_wr && (reg_addr == A_DMA);
  assign wr_clr = reg_wr && (reg_addr == A_CLR);

  assign tx_wdata = reg_wdata[DW-1:0];
  assign tx_push  = reg_wr && (reg_addr == A_TXD) && !tx_full && !tx_flush;
  assign rx_pop   = reg_rd && (reg_addr == A_RXD) && !rx_empty && !rx_flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txe_en   <= 1'b0;
      und_en   <= 1'b0;
      rxf_en   <= 1'b0;
      tx_thr_f <= '0;
      rx_thr_f <= '0;
      tx_dlvl  <= '0;
      rx_dlvl  <= '0;
      tx_den   <= 1'b0;
      rx_den   <= 1'b0;
      tx_flush <= 1'b0;
      rx_flush <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (wr_ctl) begin
        txe_en   <= reg_wdata[B_TXE_EN];
        und_en   <= reg_wdata[B_UND_EN];
        rxf_en   <= reg_wdata[B_RXF_EN];
        tx_thr_f <= reg_wdata[B_TX_THR +: TW];
        rx_thr_f <= reg_wdata[B_RX_THR +: TW];
      end
      if (wr_dma) begin
        tx_dlvl <= reg_wdata[B_TXDMA_LVL +: TW];
        tx_den  <= reg_wdata[B_TXDMA_EN];
        rx_dlvl <= reg_wdata[B_RXDMA_LVL +: TW];
        rx_den  <= reg_wdata[B_RXDMA_EN];
      end
      tx_flush <= wr_clr && reg_wdata[B_CLR_TX];
      rx_flush <= wr_clr && reg_wdata[B_CLR_RX];
      if (underrun_evt)
        underrun <= 1'b1;
      else if (wr_ctl && reg_wdata[B_UND_CLR])
        underrun <= 1'b0;
    end
  end

  assign txe_st = (tx_level <= (LW'(tx_thr_f) + LW'(1)));
  assign rxf_st = (rx_level >= (LW'(rx_thr_f) + LW'(1)));

  assign irq        = (txe_st && txe_en) || (underrun && und_en) || (rxf_st && rxf_en);
  assign tx_dma_req = tx_den && (tx_level <= LW'(tx_dlvl));
  assign rx_dma_req = rx_den && (rx_level > LW'(rx_dlvl));

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTL: begin
        reg_rdata[B_TXE_EN]         = txe_en;
        reg_rdata[B_UND_EN]         = und_en;
        reg_rdata[B_RXF_EN]         = rxf_en;
        reg_rdata[B_TX_THR +: TW]   = tx_thr_f;
        reg_rdata[B_RX_THR +: TW]   = rx_thr_f;
      end
      A_STAT: begin
        reg_rdata[0]  = txe_st;
        reg_rdata[1]  = underrun;
        reg_rdata[16] = rxf_st;
      end
      A_DMA: begin
        reg_rdata[B_TXDMA_LVL +: TW] = tx_dlvl;
        reg_rdata[B_TXDMA_EN]        = tx_den;
        reg_rdata[B_RXDMA_LVL +: TW] = rx_dlvl;
        reg_rdata[B_RXDMA_EN]        = rx_den;
      end
      A_CLR: begin
        reg_rdata[B_CLR_TX] = tx_flush;
        reg_rdata[B_CLR_RX] = rx_flush;
      end
      A_RXD:   reg_rdata[DW-1:0] = rx_head;
      A_TXL:   reg_rdata[LW-1:0] = tx_level;
      A_RXL:   reg_rdata[LW-1:0] = rx_level;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/audio_fifo_ctl.sv
module audio_fifo_ctl
  import afc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int TW   = $clog2(DEPTH),
  localparam int LW   = TW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [DW-1:0]    tx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [DW-1:0]    rx_data,
  output logic             irq,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);
  logic          q_flush [N_PATH];
  logic          q_push  [N_PATH];
  logic [DW-1:0] q_din   [N_PATH];
  logic          q_pop   [N_PATH];
  logic [DW-1:0] q_head  [N_PATH];
  logic [LW-1:0] q_level [N_PATH];
  logic          q_empty [N_PATH];
  logic          q_full  [N_PATH];

  logic          tx_push, rx_pop, tx_flush, rx_flush, underrun;
  logic [DW-1:0] tx_wdata;
  logic [LW-1:0] tx_level, rx_level;

  assign tx_level = q_level[P_TX];
  assign rx_level = q_level[P_RX];

  assign tx_valid = !q_empty[P_TX] && !tx_flush;
  assign tx_data  = q_head[P_TX];
  assign rx_ready = !q_full[P_RX] && !rx_flush;

  assign q_flush[P_TX] = tx_flush;
  assign q_push[P_TX]  = tx_push;
  assign q_din[P_TX]   = tx_wdata;
  assign q_pop[P_TX]   = tx_valid && tx_ready;

  assign q_flush[P_RX] = rx_flush;
  assign q_push[P_RX]  = rx_valid && rx_ready;
  assign q_din[P_RX]   = rx_data;
  assign q_pop[P_RX]   = rx_pop;

  for (genvar g = 0; g < N_PATH; g++) begin : g_q
    afc_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (q_flush[g]),
      .push      (q_push[g]),
      .push_data (q_din[g]),
      .pop       (q_pop[g]),
      .head      (q_head[g]),
      .level     (q_level[g]),
      .empty     (q_empty[g]),
      .full      (q_full[g])
    );
  end

  afc_regs #(.DW(DW), .TW(TW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .tx_full      (q_full[P_TX]),
    .rx_empty     (q_empty[P_RX]),
    .rx_head      (q_head[P_RX]),
    .underrun_evt (tx_ready && q_empty[P_TX]),
    .tx_push      (tx_push),
    .tx_wdata     (tx_wdata),
    .rx_pop       (rx_pop),
    .tx_flush     (tx_flush),
    .rx_flush     (rx_flush),
    .underrun     (underrun),
    .irq          (irq),
    .tx_dma_req   (tx_dma_req),
    .rx_dma_req   (rx_dma_req)
  );
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic          wd0,
  input logic          wd2,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          rx_ready,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_flush,
  input logic          underrun
);
  logic clr_tx_wr, und_clr_wr;
  assign clr_tx_wr  = reg_wr && (reg_addr == 3'd3) && wd0;
  assign und_clr_wr = reg_wr && (reg_addr == 3'd0) && wd2;

  assert_level_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == LW'(DEPTH) && !(tx_valid && tx_ready) && !tx_flush)
      |=> (tx_level == LW'(DEPTH)));

  assert_underrun_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_level == '0) |=> underrun);

  assert_underrun_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !und_clr_wr) |=> underrun);

  assert_flush_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !clr_tx_wr) |=> (!tx_flush && tx_level == '0));

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !clr_tx_wr) |=> (tx_valid && $stable(tx_data)));

  assert_rx_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == LW'(DEPTH)) |-> !rx_ready);
endmodule

bind audio_fifo_ctl afc_checker #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .wd0      (reg_wdata[0]),
  .wd2      (reg_wdata[2]),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .rx_ready (rx_ready),
  .tx_level (tx_level),
  .rx_level (rx_level),
  .tx_flush (tx_flush),
  .underrun (underrun)
);

// File: tb/audio_fifo_ctl_test.sv
`timescale 1ns/1ps
module audio_fifo_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_data = '0;
  logic        irq, tx_dma_req, rx_dma_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  audio_fifo_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic rd_pop(output logic [31:0] d);
    reg_addr = 3'd5; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic tx_take(output logic v, output logic [31:0] d);
    tx_ready = 1'b1;
    #1 begin v = tx_valid; d = tx_data; end
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic rx_give(input logic [31:0] d, output logic r);
    rx_valid = 1'b1; rx_data = d;
    #1 r = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd6, v); check("R9", "tx level", v, 0);
    rd(3'd7, v); check("R9", "rx level", v, 0);
    rd(3'd0, v); check("R9", "ctl", v, 0);
    rd(3'd1, v); check("R9", "status", v, 32'h1);
    rd(3'd3, v); check("R9", "clear", v, 0);
    check("R9", "irq", irq, 0);
    check("R9", "tx_valid", tx_valid, 0);
    check("R9", "rx_ready", rx_ready, 1);
    check("R9", "dma reqs", {tx_dma_req, rx_dma_req}, 0);
  endtask

  task automatic t_order();
    logic [31:0] v, d; logic ok;
    for (int i = 0; i < 5; i++) wr(3'd4, 32'hA0 + i);
    rd(3'd6, v); check("R1", "level after 5", v, 5);
    check("R8", "held word", tx_data, 32'hA0);
    check("R8", "valid held", tx_valid, 1);
    for (int i = 0; i < 5; i++) begin
      tx_take(ok, d);
      check("R1", "valid on pop", ok, 1);
      check("R1", "order", d, 32'hA0 + i);
    end
    rd(3'd6, v); check("R1", "level drained", v, 0);
  endtask

  task automatic t_full();
    logic [31:0] v, d; logic ok;
    for (int i = 0; i < 33; i++) wr(3'd4, 32'h100 + i);
    rd(3'd6, v); check("R1", "level 32 in 6 bits", v, 32);
    for (int i = 0; i < 32; i++) begin
      tx_take(ok, d);
      check("R2", "word after overfill", d, 32'h100 + i);
    end
    check("R2", "no extra word", tx_valid, 0);
  endtask

  task automatic t_thresh();
    logic [31:0] v; logic ok; logic [31:0] d;
    wr(3'd0, 32'h31);
    rd(3'd0, v); check("R10", "ctl readback", v, 32'h31);
    check("R3", "irq at level 0", irq, 1);
    for (int i = 0; i < 4; i++) wr(3'd4, i);
    rd(3'd1, v); check("R3", "status at thr", v[0], 1);
    check("R3", "irq at thr", irq, 1);
    wr(3'd4, 32'h4);
    rd(3'd1, v); check("R3", "status above thr", v[0], 0);
    check("R3", "irq above thr", irq, 0);
    wr(3'd0, 32'h30);
    tx_take(ok, d);
    rd(3'd1, v); check("R3", "status back at thr", v[0], 1);
    check("R3", "irq masked", irq, 0);
    for (int i = 0; i < 4; i++) tx_take(ok, d);
  endtask

  task automatic t_underrun();
    logic [31:0] v, d; logic ok;
    wr(3'd0, 32'h0);
    rd(3'd1, v); check("R4", "no underrun yet", v[1], 0);
    tx_take(ok, d);
    check("R4", "empty not valid", ok, 0);
    rd(3'd1, v); check("R4", "underrun set", v[1], 1);
    check("R4", "irq masked", irq, 0);
    wr(3'd0, 32'h2);
    check("R4", "irq enabled", irq, 1);
    rd(3'd1, v); check("R4", "underrun sticky", v[1], 1);
    wr(3'd0, 32'h6);
    rd(3'd1, v); check("R4", "underrun cleared", v[1], 0);
    check("R4", "irq after clear", irq, 0);
    rd(3'd0, v); check("R10", "clear bit reads 0", v, 32'h2);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_tx_flush();
    logic [31:0] v, d; logic ok;
    for (int i = 0; i < 4; i++) wr(3'd4, 32'h200 + i);
    wr(3'd3, 32'h1);
    reg_addr = 3'd3;
    #1 begin
      check("R6", "clear pending", reg_rdata, 32'h1);
      check("R6", "tx blocked", tx_valid, 0);
    end
    @(negedge clk);
    rd(3'd3, v); check("R6", "clear self-reset", v, 0);
    rd(3'd6, v); check("R6", "tx emptied", v, 0);
    wr(3'd4, 32'h55);
    tx_take(ok, d); check("R6", "usable after flush", d, 32'h55);
  endtask

  task automatic t_rx();
    logic [31:0] v; logic r;
    wr(3'd0, 32'h0021_0000);
    rx_give(32'hC0, r); rx_give(32'hC1, r);
    rd(3'd7, v); check("R1", "rx level 2", v, 2);
    rd(3'd1, v); check("R5", "below thr", v[16], 0);
    check("R5", "irq below", irq, 0);
    rx_give(32'hC2, r);
    rd(3'd1, v); check("R5", "at thr", v[16], 1);
    check("R5", "irq at thr", irq, 1);
    rd_pop(v); check("R1", "rx first", v, 32'hC0);
    check("R5", "irq after pop", irq, 0);
    for (int i = 0; i < 30; i++) begin
      rx_give(32'hD00 + i, r);
      check("R8", "rx accepts", r, 1);
    end
    rx_give(32'hEEE, r);
    check("R8", "rx full backpressure", r, 0);
    rd(3'd7, v); check("R8", "rx level held", v, 32);
    rd_pop(v); check("R1", "rx order a", v, 32'hC1);
    rd_pop(v); check("R1", "rx order b", v, 32'hC2);
    for (int i = 0; i < 30; i++) begin
      rd_pop(v); check("R1", "rx order", v, 32'hD00 + i);
    end
    rd(3'd7, v); check("R8", "rx drained, extra dropped", v, 0);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_rx_flush();
    logic [31:0] v; logic r;
    for (int i = 0; i < 3; i++) rx_give(32'h300 + i, r);
    wr(3'd3, 32'h2);
    reg_addr = 3'd3;
    #1 begin
      check("R6", "rx clear pending", reg_rdata, 32'h2);
      check("R6", "rx blocked", rx_ready, 0);
    end
    @(negedge clk);
    rd(3'd3, v); check("R6", "rx clear self-reset", v, 0);
    rd(3'd7, v); check("R6", "rx emptied", v, 0);
  endtask

  task automatic t_dma();
    logic [31:0] v; logic r;
    wr(3'd2, 32'h0101_0102);
    rd(3'd2, v); check("R7", "dma readback", v, 32'h0101_0102);
    check("R7", "tx req empty", tx_dma_req, 1);
    check("R7", "rx req empty", rx_dma_req, 0);
    for (int i = 0; i < 2; i++) wr(3'd4, i);
    check("R7", "tx req at level", tx_dma_req, 1);
    wr(3'd4, 32'h2);
    check("R7", "tx req above", tx_dma_req, 0);
    rx_give(32'h1, r);
    check("R7", "rx req at level", rx_dma_req, 0);
    rx_give(32'h2, r);
    check("R7", "rx req above", rx_dma_req, 1);
    wr(3'd3, 32'h3);
    @(negedge clk);
    wr(3'd2, 32'h0);
    check("R7", "reqs off", {tx_dma_req, rx_dma_req}, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_thresh();
    t_underrun();
    t_tx_flush();
    t_rx();
    t_rx_flush();
    t_dma();
    done = 1;
    summary();
  end
endmodule